// File: doc/BRIEF.md
# Single-precision result packer

This block takes a floating-point value held in a wide working form (class code, sign, unbiased exponent, and a left-aligned mantissa with extra low-order bits and a separate sticky bit) and turns it into a 32-bit IEEE-754 single-precision word. It sits at the end of an arithmetic pipeline, where results are held with more precision than the storage format allows. Here the final rounding, denormalization and overflow handling take place.

Each operation is presented with `in_valid` for one cycle. The packed word and two flags appear one cycle later with `out_valid`. The flags describe only that operation. Special classes (zero, infinity, NaN) bypass rounding. Finite numbers are rounded in one of four directions. Results that are too small are shifted into the subnormal range. Results that are too large become either infinity or the largest finite value, depending on the rounding direction and the sign.

Top module: `fp32_packer`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and is low otherwise. Each result corresponds to the input accepted one cycle earlier.
- R2: Class code 0 (zero) yields the sign bit with the other 31 bits zero and both flags clear.
- R3: Class code 2 (infinity) yields the sign, exponent field 255 and a zero fraction, with both flags clear.
- R4: Class code 3 (NaN) yields the sign and exponent field 255. The fraction is `in_mant[MANT_W-2 -: 23]`, with fraction bit 22 (the quiet bit) forced to 1. Both flags are clear.
- R5: Class code 1 (number) rounds the 24 bits `in_mant[MANT_W-1 -: 24]` (bit MANT_W-1 is the hidden one). The next bit below is guard and the one after it is round. All lower bits ORed with `in_sticky` form sticky. The modes are: `rnd_mode` 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R6: `out_inexact` is set when guard, round or sticky is nonzero, and also on overflow. It is clear otherwise, regardless of earlier operations.
- R7: For a normal result, a rounding carry out of the mantissa raises the exponent field by one and leaves the fraction zero.
- R8: When the exponent plus 127 is 0 or less, the mantissa (hidden one included) is shifted right by one minus that biased exponent before rounding. Bits shifted out feed sticky. The result has exponent field 0, and no flag other than inexact can be set.
- R9: A subnormal whose rounding carries into the hidden position becomes exponent field 1 with a zero fraction.
- R10: When the final biased exponent of a number is 255 or more, both `out_operr` and `out_inexact` are set.
- R11: On overflow the result is signed infinity in three cases: mode 0; mode 2 with a positive sign; mode 3 with a negative sign.
- R12: In every other overflow case the result is the largest finite value of the same sign: exponent field 254 with all fraction bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, hidden one at the top |
| in_sticky | input | 1 | OR of precision already discarded upstream |
| rnd_mode | input | 2 | Rounding direction |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Packed single-precision word |
| out_operr | output | 1 | Overflow operand error |
| out_inexact | output | 1 | Result differs from the exact value |

## Verification
The bench uses the default parameters: a 10-bit signed exponent and a 28-bit mantissa. With these, every input reaches bits below the round bit, so sticky comes both from `in_sticky` and from the mantissa tail. The exponent range of ±511 covers overflow well above 255. It also covers denormalization shifts that push the hidden one entirely into sticky. Directed vectors cover the rounding ties, the carry to the next exponent, the carry from subnormal to normal, and each mode and sign on overflow. Random vectors then fill in the space around these cases.

// File: rtl/fp32_packer.sv
module fp32_packer #(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  logic [1:0]              rnd_mode,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    out_operr,
  output logic                    out_inexact
);
  localparam int FRAC_W = 23;
  localparam int BIAS   = 127;
  localparam int EMAX   = 255;
  localparam int BE_W   = EXP_W + 2;
  localparam int SH_W   = $clog2(MANT_W + 1) + 1;
  localparam int XW     = 2 * MANT_W;
  localparam int KW     = FRAC_W + 1;

  logic signed [BE_W-1:0] bexp, shraw, eadj;
  logic                   subn, g, r, s, up, inex, ovf, to_inf;
  logic [SH_W-1:0]        sh;
  logic [XW-1:0]          ext;
  logic [KW-1:0]          kept;
  logic [KW:0]            sum;
  logic [31:0]            word_num, word_n;
  logic                   operr_n, inex_n;

  assign bexp  = BE_W'(in_exp) + BE_W'(BIAS);
  assign subn  = (bexp <= 0);
  assign shraw = BE_W'(1) - bexp;

  always_comb begin
    if (!subn)
      sh = '0;
    else if (shraw > BE_W'(MANT_W))
      sh = SH_W'(MANT_W);
    else
      sh = shraw[SH_W-1:0];
  end

  assign ext  = {in_mant, {MANT_W{1'b0}}} >> sh;
  assign kept = ext[XW-1 -: KW];
  assign g    = ext[XW-KW-1];
  assign r    = ext[XW-KW-2];
  assign s    = (|ext[XW-KW-3:0]) | in_sticky;
  assign inex = g | r | s;

  always_comb begin
    case (rnd_mode)
      2'd0:    up = g & (r | s | kept[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = ~in_sign & inex;
      default: up = in_sign & inex;
    endcase
  end

  assign sum    = {1'b0, kept} + (KW+1)'(up);
  assign eadj   = bexp + BE_W'(sum[KW]);
  assign ovf    = ~subn & (eadj >= BE_W'(EMAX));
  assign to_inf = (rnd_mode == 2'd0) | ((rnd_mode == 2'd2) & ~in_sign) |
                  ((rnd_mode == 2'd3) & in_sign);

  always_comb begin
    if (subn)
      word_num = {in_sign, 7'd0, sum[FRAC_W], sum[FRAC_W-1:0]};
    else if (ovf)
      word_num = to_inf ? {in_sign, 8'hFF, {FRAC_W{1'b0}}}
                        : {in_sign, 8'hFE, {FRAC_W{1'b1}}};
    else
      word_num = {in_sign, eadj[7:0], sum[FRAC_W-1:0]};
  end

  always_comb begin
    word_n  = {in_sign, 31'd0};
    operr_n = 1'b0;
    inex_n  = 1'b0;
    case (in_class)
      2'd0: word_n = {in_sign, 31'd0};
      2'd1: begin
        word_n  = word_num;
        operr_n = ovf;
        inex_n  = inex | ovf;
      end
      2'd2: word_n = {in_sign, 8'hFF, {FRAC_W{1'b0}}};
      default: word_n = {in_sign, 8'hFF, 1'b1, in_mant[MANT_W-3 -: FRAC_W-1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_operr   <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word    <= word_n;
        out_operr   <= operr_n;
        out_inexact <= inex_n;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd0) |=> (out_word[30:0] == 31'd0 && !out_operr && !out_inexact));
  // R4
  nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd3) |=> (out_word[30:22] == 9'h1FF));
  // R10
  ovf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_operr) |-> (out_inexact && out_word[30:23] >= 8'hFE));
  // R12
  rz_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1 && rnd_mode == 2'd1) |=> (out_word[30:23] != 8'hFF));
  // R8
  subn_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1 && subn) |=> !out_operr);
endmodule

// File: tb/fp32_packer_test.sv
module fp32_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = '0;
  logic        in_sign = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [27:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_operr, out_inexact;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [33:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  fp32_packer uut (.*);

  function automatic logic [33:0] model(logic [1:0] cls, logic sg, int e,
                                        logic [27:0] m, logic st, logic [1:0] md);
    logic [31:0] w;
    logic op, ix, g, r, s, up;
    logic [63:0] mm;
    logic [23:0] kept;
    logic [24:0] k;
    int be;
    op = 1'b0; ix = 1'b0;
    case (cls)
      2'd0: w = {sg, 31'd0};
      2'd2: w = {sg, 8'hFF, 23'd0};
      2'd3: w = {sg, 8'hFF, 1'b1, m[25:4]};
      default: begin
        be = e + 127;
        mm = 64'(m);
        s = st;
        if (be <= 0)
          for (int i = 0; i < 1 - be && i < 40; i++) begin
            s = s | mm[0];
            mm = mm >> 1;
          end
        kept = mm[27:4];
        g = mm[3];
        r = mm[2];
        s = s | mm[1] | mm[0];
        ix = g | r | s;
        case (md)
          2'd0: up = g && (r || s || kept[0]);
          2'd1: up = 1'b0;
          2'd2: up = !sg && ix;
          default: up = sg && ix;
        endcase
        k = 25'(kept) + 25'(up);
        if (be <= 0) w = {sg, 7'd0, k[23], k[22:0]};
        else begin
          if (k[24]) be = be + 1;
          if (be >= 255) begin
            op = 1'b1; ix = 1'b1;
            if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg))
              w = {sg, 8'hFF, 23'd0};
            else
              w = {sg, 8'hFE, 23'h7FFFFF};
          end else w = {sg, be[7:0], k[22:0]};
        end
      end
    endcase
    return {op, ix, w};
  endfunction

  task automatic apply(string tag, logic [1:0] cls, logic sg, int e,
                       logic [27:0] m, logic st, logic [1:0] md);
    exp_t x;
    in_valid = 1'b1; in_class = cls; in_sign = sg; in_exp = 10'(e);
    in_mant = m; in_sticky = st; rnd_mode = md;
    x.v = model(cls, sg, e, m, st, md);
    x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R1: result with no pending input, actual word %h expected none", out_word);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if ({out_operr, out_inexact, out_word} !== x.v) begin
          n_bad++;
          $display("FAIL %s: actual op=%b ix=%b w=%h expected op=%b ix=%b w=%h",
                   x.tag, out_operr, out_inexact, out_word, x.v[33], x.v[32], x.v[31:0]);
        end
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_word !== 32'd0) begin
      n_bad++;
      $display("FAIL R1: reset state actual v=%b w=%h expected v=0 w=0", out_valid, out_word);
    end
    rst_n = 1'b1;
    @(negedge clk);
    apply("R2 +zero", 2'd0, 1'b0, 0, 28'h0, 1'b0, 2'd0);
    apply("R2 -zero", 2'd0, 1'b1, 5, 28'h8000001, 1'b1, 2'd2);
    apply("R3 +inf", 2'd2, 1'b0, 0, 28'h8000000, 1'b0, 2'd1);
    apply("R3 -inf", 2'd2, 1'b1, 0, 28'hFFFFFFF, 1'b1, 2'd3);
    apply("R4 nan payload", 2'd3, 1'b0, 0, 28'hCABCDE0, 1'b0, 2'd0);
    apply("R4 nan quiet forced", 2'd3, 1'b1, 0, 28'h8012340, 1'b1, 2'd1);
    apply("R5 one exact", 2'd1, 1'b0, 0, 28'h8000000, 1'b0, 2'd0);
    apply("R5 tie even down", 2'd1, 1'b0, 0, 28'h8000008, 1'b0, 2'd0);
    apply("R5 tie odd up", 2'd1, 1'b0, 0, 28'h8000018, 1'b0, 2'd0);
    apply("R5 above half", 2'd1, 1'b0, 0, 28'h8000009, 1'b0, 2'd0);
    apply("R5 rz truncate", 2'd1, 1'b0, 0, 28'h800000F, 1'b1, 2'd1);
    apply("R5 rp pos sticky", 2'd1, 1'b0, 0, 28'h8000000, 1'b1, 2'd2);
    apply("R5 rm pos sticky", 2'd1, 1'b0, 0, 28'h8000000, 1'b1, 2'd3);
    apply("R5 rm neg sticky", 2'd1, 1'b1, 0, 28'h8000000, 1'b1, 2'd3);
    apply("R6 exact clears", 2'd1, 1'b1, 3, 28'hA5A5A50, 1'b0, 2'd2);
    apply("R7 carry exponent", 2'd1, 1'b0, 0, 28'hFFFFFF8, 1'b0, 2'd0);
    apply("R7 carry rp", 2'd1, 1'b0, -20, 28'hFFFFFF0, 1'b1, 2'd2);
    apply("R8 subnormal shift1", 2'd1, 1'b0, -127, 28'h8000000, 1'b0, 2'd0);
    apply("R8 subnormal shift4", 2'd1, 1'b1, -130, 28'h8000000, 1'b0, 2'd0);
    apply("R8 deep rp", 2'd1, 1'b0, -200, 28'h8000000, 1'b0, 2'd2);
    apply("R8 deep rn", 2'd1, 1'b0, -200, 28'h8000000, 1'b0, 2'd0);
    apply("R8 sub sticky from shift", 2'd1, 1'b0, -140, 28'h8000010, 1'b0, 2'd1);
    apply("R9 sub to min normal", 2'd1, 1'b0, -127, 28'hFFFFFFF, 1'b0, 2'd0);
    apply("R9 sub to min normal rm", 2'd1, 1'b1, -127, 28'hFFFFFE0, 1'b1, 2'd3);
    apply("R10 R11 ovf rn pos", 2'd1, 1'b0, 128, 28'h8000000, 1'b0, 2'd0);
    apply("R10 R11 ovf rn neg", 2'd1, 1'b1, 300, 28'h8000000, 1'b0, 2'd0);
    apply("R12 ovf rz pos", 2'd1, 1'b0, 128, 28'h8000000, 1'b0, 2'd1);
    apply("R12 ovf rz neg", 2'd1, 1'b1, 128, 28'h8000000, 1'b0, 2'd1);
    apply("R11 ovf rp pos", 2'd1, 1'b0, 200, 28'h8000000, 1'b0, 2'd2);
    apply("R12 ovf rp neg", 2'd1, 1'b1, 200, 28'h8000000, 1'b0, 2'd2);
    apply("R12 ovf rm pos", 2'd1, 1'b0, 129, 28'h8000000, 1'b0, 2'd3);
    apply("R11 ovf rm neg", 2'd1, 1'b1, 129, 28'h8000000, 1'b0, 2'd3);
    apply("R10 carry into ovf", 2'd1, 1'b0, 127, 28'hFFFFFF8, 1'b0, 2'd0);
    apply("R10 max finite exact", 2'd1, 1'b0, 127, 28'hFFFFFF0, 1'b0, 2'd0);
    apply("R6 flags fresh", 2'd1, 1'b0, 1, 28'h8000000, 1'b0, 2'd0);
    for (int i = 0; i < 600; i++) begin
      logic [1:0] c;
      int e;
      c = ($urandom_range(0, 9) < 7) ? 2'd1 : 2'($urandom);
      e = $urandom_range(0, 340) - 170;
      apply("R5 R8 R10 random", c, 1'($urandom), e, {1'b1, 27'($urandom)},
            1'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R1: pending results actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule